// File: doc/BRIEF.md
# Home-Node Directory Tracker

This block is the directory at the home node of a range of memory lines in a cache-coherent multiprocessor. For each line it records which processors hold a copy (one bit per processor) and whether one processor holds it modified. Read and write-ownership requests arrive tagged with the requesting processor. The block sends invalidate or forward messages only to the processors its bitmap names, never to all of them. It collects one acknowledgement from each addressed processor and then grants the request.

Each line has one home entry. A line with a transaction in flight is busy. Further requests to that line are refused with a negative acknowledgement, and the requester retries. Only one transaction is in flight at a time. A request to any other line is held off with `req_ready` low until the busy line is released. Eviction notices remove a processor from the bitmap. Caches, memory data and the network are outside the block.

Request codes on `req_op`: 0 = read, 1 = write (ownership), 2 = clean eviction, 3 = dirty eviction. In `snp_mask`, bit *n* addresses processor *n*. `snp_inval` is 1 for an invalidate and 0 for a forward/writeback request.

Top module: `dir_home_tracker`

## Requirements
- R1: After a synchronous active-low reset, no grant, refusal or coherence message is issued, `req_ready` is high and every line is uncached, so a first read of any line is granted with no message.
- R2: A read of a line with no modified holder other than the requester is granted on the cycle after acceptance, with no coherence message, and adds the requester to the bitmap.
- R3: A read of a line held modified by another processor sends one forward message (`snp_inval`=0) addressed only to that owner. The grant follows that owner's acknowledgement, after which the line is shared and unmodified.
- R4: A write sends one invalidate (`snp_inval`=1) on the cycle after acceptance. It is addressed to every recorded holder except the requester, including processors 0 and NPROC-1.
- R5: A transaction is granted on the cycle after the last awaited acknowledgement arrives, and not before. Acknowledgements from processors that were not addressed have no effect.
- R6: After a write completes, the requester is the sole holder and is marked modified. A later write by another processor invalidates only it, and a later read forwards only to it.
- R7: A request to the busy line is accepted and refused: `nack_valid` pulses on the next cycle with `nack_dst` set to the requester, and the directory entry is left unchanged.
- R8: While a line is busy, a request to a different line sees `req_ready` low and is not acted on.
- R9: An eviction removes the sender from the bitmap and is granted at once. A write to a line with no remaining holders is granted with no message.
- R10: A dirty eviction by the modified owner clears the modified state, so a following read by another processor is granted with no forward message.
- R11: When the last acknowledgement and a refused request to the same line arrive in the same cycle, the grant and the refusal are both issued on the next cycle, each to its own processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | Request code (0 read, 1 write, 2 clean evict, 3 dirty evict) |
| req_line | input | LW (4) | Line index within the home range |
| req_src | input | PW (5) | Requesting processor |
| ack_valid | input | 1 | Acknowledgement present |
| ack_src | input | PW (5) | Processor sending the acknowledgement |
| snp_valid | output | 1 | Coherence message pulse |
| snp_inval | output | 1 | 1 invalidate, 0 forward/writeback |
| snp_mask | output | NPROC (32) | Target processors, one bit each |
| snp_line | output | LW (4) | Line the message concerns |
| gnt_valid | output | 1 | Grant pulse |
| gnt_dst | output | PW (5) | Processor being granted |
| gnt_line | output | LW (4) | Line granted |
| nack_valid | output | 1 | Refusal pulse |
| nack_dst | output | PW (5) | Processor being refused |

## Verification
The two functions that can coincide are the completion of an in-flight transaction and the refusal of a newcomer to the same line. The bench presents the owner's acknowledgement and a write request to the busy line in one cycle. It then expects a grant to the original requester and a refusal to the newcomer on the same following cycle. A read after that refusal is granted without messages, which shows the refused write left the entry untouched.

// File: rtl/dirtrk_pkg.sv
// Package: shared request codes for the home-node directory tracker.
// Assumes: the requester drives one of these codes on req_op.
package dirtrk_pkg;
    typedef enum logic [1:0] {
        OP_READ        = 2'd0,
        OP_WRITE       = 2'd1,
        OP_EVICT_CLEAN = 2'd2,
        OP_EVICT_DIRTY = 2'd3
    } dir_op_e;
endpackage

// File: rtl/dir_entry_ram.sv
// dir_entry_ram: one directory entry per line (holder bitmap, modified flag,
// owner id). One combinational read port and one write port.
// Assumes: the controller writes at most one entry per cycle.
module dir_entry_ram #(
    parameter int NPROC  = 32,
    parameter int NLINES = 16,
    localparam int PW = $clog2(NPROC),
    localparam int LW = $clog2(NLINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    rd_line,
    output logic [NPROC-1:0] rd_sharers,
    output logic             rd_dirty,
    output logic [PW-1:0]    rd_owner,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_line,
    input  logic [NPROC-1:0] wr_sharers,
    input  logic             wr_dirty,
    input  logic [PW-1:0]    wr_owner
);
    logic [NPROC-1:0] sharers_q [NLINES];
    logic             dirty_q   [NLINES];
    logic [PW-1:0]    owner_q   [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        // Purpose: hold and update the entry of line g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sharers_q[g] <= '0;
                dirty_q[g]   <= 1'b0;
                owner_q[g]   <= '0;
            end else if (wr_en && wr_line == LW'(g)) begin
                sharers_q[g] <= wr_sharers;
                dirty_q[g]   <= wr_dirty;
                owner_q[g]   <= wr_owner;
            end
        end
    end

    // Purpose: present the addressed entry.
    always_comb begin
        rd_sharers = sharers_q[rd_line];
        rd_dirty   = dirty_q[rd_line];
        rd_owner   = owner_q[rd_line];
    end

    AST_DIRTY_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_dirty |-> $countones(wr_sharers) <= 1); // R6
endmodule

// File: rtl/dir_ack_tracker.sv
// dir_ack_tracker: remembers which processors still owe an acknowledgement
// and flags the one that empties the set.
// Assumes: load only when nothing is outstanding; stray acks are dropped.
module dir_ack_tracker #(
    parameter int NPROC = 32,
    localparam int PW = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NPROC-1:0] load_mask,
    input  logic             ack_valid,
    input  logic [PW-1:0]    ack_src,
    output logic [NPROC-1:0] pending,
    output logic             last_ack
);
    logic [NPROC-1:0] ack_bit;

    // Purpose: decode the acknowledging processor and detect the final one.
    always_comb begin
        ack_bit  = NPROC'(1) << ack_src;
        last_ack = ack_valid && ((pending & ack_bit) != '0)
                   && ((pending & ~ack_bit) == '0);
    end

    // Purpose: load a new target set or retire an acknowledged processor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else if (load)
            pending <= load_mask;
        else if (ack_valid)
            pending <= pending & ~ack_bit;
    end

    AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> pending == '0); // R5
endmodule

// File: rtl/dir_home_tracker.sv
// dir_home_tracker: home-node directory. Takes read/write/eviction requests,
// sends invalidates or forwards to recorded holders only, grants after all
// acknowledgements, refuses requests to the busy line.
// Assumes: one transaction in flight; message outputs are one-cycle pulses
// that the network always takes.
module dir_home_tracker #(
    parameter int NPROC  = 32,
    parameter int NLINES = 16,
    localparam int PW = $clog2(NPROC),
    localparam int LW = $clog2(NLINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [LW-1:0]    req_line,
    input  logic [PW-1:0]    req_src,
    input  logic             ack_valid,
    input  logic [PW-1:0]    ack_src,
    output logic             snp_valid,
    output logic             snp_inval,
    output logic [NPROC-1:0] snp_mask,
    output logic [LW-1:0]    snp_line,
    output logic             gnt_valid,
    output logic [PW-1:0]    gnt_dst,
    output logic [LW-1:0]    gnt_line,
    output logic             nack_valid,
    output logic [PW-1:0]    nack_dst
);
    import dirtrk_pkg::*;

    logic          busy;
    logic [LW-1:0] b_line;
    logic [PW-1:0] b_src;
    logic          b_write;

    logic [LW-1:0]    rd_line;
    logic [NPROC-1:0] rd_sharers;
    logic             rd_dirty;
    logic [PW-1:0]    rd_owner;
    logic             wr_en;
    logic [NPROC-1:0] wr_sharers;
    logic             wr_dirty;
    logic [PW-1:0]    wr_owner;

    logic             load;
    logic [NPROC-1:0] load_mask;
    logic [NPROC-1:0] pending;
    logic             last_ack;

    logic             accept, start, start_inval, grant_now;
    logic [PW-1:0]    grant_dst;
    logic [LW-1:0]    grant_line;
    logic [NPROC-1:0] src_bit, owner_bit, targets;
    logic             foreign_dirty;
    dir_op_e          op;

    dir_entry_ram #(.NPROC(NPROC), .NLINES(NLINES)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .rd_line(rd_line), .rd_sharers(rd_sharers), .rd_dirty(rd_dirty),
        .rd_owner(rd_owner),
        .wr_en(wr_en), .wr_line(busy ? b_line : req_line),
        .wr_sharers(wr_sharers), .wr_dirty(wr_dirty), .wr_owner(wr_owner)
    );

    dir_ack_tracker #(.NPROC(NPROC)) u_acks (
        .clk(clk), .rst_n(rst_n), .load(load), .load_mask(load_mask),
        .ack_valid(ack_valid), .ack_src(ack_src),
        .pending(pending), .last_ack(last_ack)
    );

    // Purpose: handshake and entry addressing.
    always_comb begin
        req_ready     = !busy || (req_line == b_line);
        accept        = req_valid && req_ready;
        rd_line       = busy ? b_line : req_line;
        op            = dir_op_e'(req_op);
        src_bit       = NPROC'(1) << req_src;
        owner_bit     = NPROC'(1) << rd_owner;
        foreign_dirty = rd_dirty && (rd_owner != req_src);
        targets       = (rd_sharers | (foreign_dirty ? owner_bit : '0)) & ~src_bit;
    end

    // Purpose: decide the entry update, message launch and grant this cycle.
    always_comb begin
        wr_en       = 1'b0;
        wr_sharers  = rd_sharers;
        wr_dirty    = rd_dirty;
        wr_owner    = rd_owner;
        start       = 1'b0;
        start_inval = 1'b0;
        load_mask   = '0;
        grant_now   = 1'b0;
        grant_dst   = req_src;
        grant_line  = req_line;
        if (busy) begin
            if (last_ack) begin
                wr_en      = 1'b1;
                grant_now  = 1'b1;
                grant_dst  = b_src;
                grant_line = b_line;
                if (b_write) begin
                    wr_sharers = NPROC'(1) << b_src;
                    wr_dirty   = 1'b1;
                    wr_owner   = b_src;
                end else begin
                    wr_sharers = rd_sharers | (NPROC'(1) << b_src);
                    wr_dirty   = 1'b0;
                end
            end
        end else if (accept) begin
            unique case (op)
                OP_READ: begin
                    if (foreign_dirty) begin
                        start     = 1'b1;
                        load_mask = owner_bit;
                    end else begin
                        wr_en      = 1'b1;
                        wr_sharers = rd_sharers | src_bit;
                        grant_now  = 1'b1;
                    end
                end
                OP_WRITE: begin
                    if (targets != '0) begin
                        start       = 1'b1;
                        start_inval = 1'b1;
                        load_mask   = targets;
                    end else begin
                        wr_en      = 1'b1;
                        wr_sharers = src_bit;
                        wr_dirty   = 1'b1;
                        wr_owner   = req_src;
                        grant_now  = 1'b1;
                    end
                end
                default: begin
                    wr_en      = 1'b1;
                    wr_sharers = rd_sharers & ~src_bit;
                    if (op == OP_EVICT_DIRTY && rd_dirty && rd_owner == req_src)
                        wr_dirty = 1'b0;
                    grant_now  = 1'b1;
                end
            endcase
        end
        load = start;
    end

    // Purpose: track the in-flight transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            b_line  <= '0;
            b_src   <= '0;
            b_write <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            b_line  <= req_line;
            b_src   <= req_src;
            b_write <= start_inval;
        end else if (busy && last_ack) begin
            busy <= 1'b0;
        end
    end

    // Purpose: register the message, grant and refusal pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_valid  <= 1'b0;
            snp_inval  <= 1'b0;
            snp_mask   <= '0;
            snp_line   <= '0;
            gnt_valid  <= 1'b0;
            gnt_dst    <= '0;
            gnt_line   <= '0;
            nack_valid <= 1'b0;
            nack_dst   <= '0;
        end else begin
            snp_valid  <= start;
            snp_inval  <= start_inval;
            snp_mask   <= load_mask;
            snp_line   <= req_line;
            gnt_valid  <= grant_now;
            gnt_dst    <= grant_dst;
            gnt_line   <= grant_line;
            nack_valid <= busy && accept;
            nack_dst   <= req_src;
        end
    end

    AST_SNP_SKIPS_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> busy && !snp_mask[b_src]); // R4
    AST_SNP_MATCHES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> snp_mask != '0 && pending == snp_mask); // R5
    AST_NACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        nack_valid |-> $past(busy)); // R7
    AST_BUSY_ENTRY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && $past(rst_n) |-> $stable(rd_sharers)); // R8
endmodule

// File: tb/dir_home_tracker_tb.sv
module dir_home_tracker_tb;
    localparam int NPROC  = 32;
    localparam int NLINES = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, ack_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [3:0]  req_line = '0;
    logic [4:0]  req_src = '0, ack_src = '0;
    logic        req_ready, snp_valid, snp_inval, gnt_valid, nack_valid;
    logic [31:0] snp_mask;
    logic [3:0]  snp_line, gnt_line;
    logic [4:0]  gnt_dst, nack_dst;

    int tests = 0, fails = 0;
    bit done = 0;

    // captured results of the last step
    logic g_ready, g_snp, g_inv, g_gnt, g_nack;
    logic [31:0] g_mask;
    logic [4:0]  g_gdst, g_ndst;

    always #10 clk = ~clk;

    dir_home_tracker #(.NPROC(NPROC), .NLINES(NLINES)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_line(req_line), .req_src(req_src),
        .ack_valid(ack_valid), .ack_src(ack_src),
        .snp_valid(snp_valid), .snp_inval(snp_inval), .snp_mask(snp_mask),
        .snp_line(snp_line), .gnt_valid(gnt_valid), .gnt_dst(gnt_dst),
        .gnt_line(gnt_line), .nack_valid(nack_valid), .nack_dst(nack_dst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, capture registered outputs one cycle later
    task automatic step(input logic rv, input logic [1:0] op, input logic [3:0] ln,
                        input logic [4:0] src, input logic av, input logic [4:0] asrc);
        req_valid = rv; req_op = op; req_line = ln; req_src = src;
        ack_valid = av; ack_src = asrc;
        #1 g_ready = req_ready;
        @(negedge clk);
        g_snp = snp_valid; g_inv = snp_inval; g_mask = snp_mask;
        g_gnt = gnt_valid; g_gdst = gnt_dst; g_nack = nack_valid; g_ndst = nack_dst;
        req_valid = 1'b0; ack_valid = 1'b0;
    endtask

    task automatic expect_grant(input string req, input logic [4:0] dst);
        chk(req, {g_snp, g_gnt}, 2'b01);
        chk(req, g_gdst, dst);
    endtask

    task automatic t_reset;
        chk("R1 ready", req_ready, 1);
        chk("R1 pulses", {snp_valid, gnt_valid, nack_valid}, 0);
        step(1, 0, 0, 3, 0, 0);
        expect_grant("R1 first read", 3);
    endtask

    task automatic t_reads;
        step(1, 0, 3, 5, 0, 0);  expect_grant("R2 read p5", 5);
        step(1, 0, 3, 7, 0, 0);  expect_grant("R2 read p7", 7);
    endtask

    task automatic t_write_with_waits;
        step(1, 1, 3, 5, 0, 0);
        chk("R4 inv pulse", {g_snp, g_inv, g_gnt}, 3'b110);
        chk("R4 inv mask", g_mask, 32'h0000_0080);
        step(0, 0, 0, 0, 1, 9);  chk("R5 stray ack ignored", g_gnt, 0);
        step(1, 0, 3, 1, 0, 0);
        chk("R7 nack", {g_nack, g_gnt}, 2'b10);
        chk("R7 nack dst", g_ndst, 1);
        step(1, 0, 4, 2, 0, 0);
        chk("R8 other line held", g_ready, 0);
        chk("R8 no action", {g_gnt, g_nack, g_snp}, 0);
        step(0, 0, 0, 0, 1, 7);  expect_grant("R5 grant after ack", 5);
        step(1, 0, 4, 2, 0, 0);  expect_grant("R8 other line after release", 2);
    endtask

    task automatic t_forward_and_collision;
        step(1, 0, 3, 2, 0, 0);
        chk("R3 fwd pulse", {g_snp, g_inv, g_gnt}, 3'b100);
        chk("R3 fwd to owner", g_mask, 32'h0000_0020);
        step(1, 1, 3, 8, 1, 5);
        chk("R11 grant and nack", {g_gnt, g_nack}, 2'b11);
        chk("R11 grant dst", g_gdst, 2);
        chk("R11 nack dst", g_ndst, 8);
        step(1, 0, 3, 9, 0, 0);  expect_grant("R3 now clean", 9);
    endtask

    task automatic t_multi_inv;
        step(1, 1, 3, 9, 0, 0);
        chk("R4 multi mask", g_mask, 32'h0000_0024);
        step(0, 0, 0, 0, 1, 2);  chk("R5 not yet", g_gnt, 0);
        step(0, 0, 0, 0, 1, 5);  expect_grant("R5 all acks", 9);
        step(1, 1, 3, 4, 0, 0);
        chk("R6 only writer invalidated", g_mask, 32'h0000_0200);
        step(0, 0, 0, 0, 1, 9);  expect_grant("R6 grant", 4);
    endtask

    task automatic t_evictions;
        step(1, 3, 3, 4, 0, 0);  expect_grant("R10 dirty evict", 4);
        step(1, 0, 3, 6, 0, 0);  expect_grant("R10 read no fwd", 6);
        step(1, 2, 3, 6, 0, 0);  expect_grant("R9 clean evict", 6);
        step(1, 1, 3, 1, 0, 0);  expect_grant("R9 write empty line", 1);
    endtask

    task automatic t_boundary;
        step(1, 0, 15, 31, 0, 0); expect_grant("R2 read top line", 31);
        step(1, 1, 15, 0, 0, 0);
        chk("R4 mask top proc", g_mask, 32'h8000_0000);
        step(0, 0, 0, 0, 1, 31);  expect_grant("R5 grant p0", 0);
        step(1, 0, 15, 31, 0, 0);
        chk("R6 fwd to p0", {g_snp, g_inv}, 2'b10);
        chk("R6 fwd mask", g_mask, 32'h0000_0001);
        step(0, 0, 0, 0, 1, 0);   expect_grant("R3 grant p31", 31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_reads;
        t_write_with_waits;
        t_forward_and_collision;
        t_multi_inv;
        t_evictions;
        t_boundary;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule